// File: doc/BRIEF.md
# Serial Port with Four-Byte Queues and RTS/CTS Flow Control

This block is a full-duplex asynchronous serial port. The character format is fixed: one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. The bit rate comes from a 12-bit divisor. A timing tick runs at 16 times the bit rate, and each bit lasts 16 times the divisor in clock cycles. Each direction has a small queue of four bytes.

A host uses a four-register port with these addresses:

- Address 0 is the data window. A write adds a byte to the transmit queue, and a read removes the oldest received byte.
- Address 1 holds the status flags.
- Addresses 2 and 3 hold the divisor and the flow-control enable.

When flow control is on, transmission is held off while the remote side withholds permission (`cts_i` low). The block also lowers `rts_o` while its receive queue is full.

Top module: `fcuart_top`

## Requirements
- R1: After reset `txd_o` and `rts_o` are 1. Status (address 1) reads 0x06: bit1 (transmit queue empty) and bit2 (receive queue empty) are set. Address 2 reads the low byte of the reset divisor.
- R2: A transmitted character is a 0 start bit, then data bits 0 to 7, then a 1 stop bit. Each bit lasts 16*max(D,1) clock cycles, where D is the divisor.
- R3: The divisor D is 12 bits wide. Bits 7:0 are written at address 2 and bits 11:8 at address 3, bits 3:0. A new value changes the bit length of the next character.
- R4: The transmit queue holds 4 bytes, and status bit0 reports that it is full. A data write made while the queue is full is discarded.
- R5: Address 3 bit7 enables flow control. While it is set and `cts_i` is 0, no new character starts. A character already on the line completes unchanged.
- R6: A received byte is read at address 0. The read removes it, and bytes come out in arrival order.
- R7: The receive queue holds 4 bytes, and status bit3 reports that it is full. With flow control enabled, `rts_o` is 0 while the queue is full and returns to 1 once a byte is read.
- R8: A byte that arrives while the receive queue is full is dropped, and sticky status bit4 is set. Writing 1 to bit4 of address 1 clears it.
- R9: Status bit5 shows the framing-error mark of the oldest received byte. The mark is set when that byte's stop bit was sampled low.
- R10: The receiver checks the start bit again at its midpoint. A low pulse shorter than half a bit stores no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops receive data at address 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| cts_i | input | 1 | Remote permission to send (active high) |
| rts_o | output | 1 | Ready to receive (active high) |

## Verification
The hardest condition to reach from the ports is a receive overrun: four bytes sit unread and a fifth arrives, with flow control on. The bench reaches it by driving five complete serial frames into `rxd_i` without reading any of them. Along the way it checks that `rts_o` falls after the fourth byte and that the sticky flag rises after the fifth. The bench also holds `cts_i` low while writing five bytes, which fills the transmit queue and shows the discarded write. It drops `cts_i` just after a start edge to show that a character already on the line finishes.

// File: rtl/fcuart_pkg.sv
package fcuart_pkg;
   localparam int DIV_W   = 12;
   localparam int OVS     = 16;
   localparam int OVS_W   = $clog2(OVS);
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
   typedef enum logic [1:0] {REG_DATA = 2'd0, REG_STAT = 2'd1, REG_DIVL = 2'd2, REG_CTRL = 2'd3} reg_addr_t;
endpackage

// File: rtl/fcuart_fifo.sv
module fcuart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("fcuart_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R8
   full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> $stable(count));
endmodule

// File: rtl/fcuart_baud.sv
module fcuart_baud
   import fcuart_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (div == '0) ? DIV_W'(0) : div - 1'b1;
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fcuart_tx.sv
module fcuart_tx
   import fcuart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start_ok,
   input  logic [7:0] data,
   output logic       pop,
   output logic       busy,
   output logic       txd
);
   logic [9:0]       sh;
   logic [OVS_W-1:0] tcnt;
   logic [3:0]       bitn;

   assign pop = !busy && tick && start_ok;
   assign txd = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         tcnt <= '0;
         bitn <= '0;
         busy <= 1'b0;
      end else if (!busy) begin
         if (pop) begin
            sh   <= {1'b1, data, 1'b0};
            tcnt <= '0;
            bitn <= '0;
            busy <= 1'b1;
         end
      end else if (tick) begin
         tcnt <= tcnt + 1'b1;
         if (tcnt == OVS_W'(OVS-1)) begin
            sh   <= {1'b1, sh[9:1]};
            bitn <= bitn + 1'b1;
            if (bitn == 4'd9) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fcuart_rx.sv
module fcuart_rx
   import fcuart_pkg::*;
#(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   output logic       push,
   output logic [7:0] data,
   output logic       ferr
);
   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("fcuart_rx: SYNC must be at least 2");
      end
   endgenerate

   logic [SYNC-1:0]  sr;
   logic             rx_s;
   rx_state_t        st;
   logic [OVS_W-1:0] tcnt;
   logic [2:0]       bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[SYNC-2:0], rxd};
   end
   assign rx_s = sr[SYNC-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         tcnt <= '0;
         bitn <= '0;
         data <= '0;
         push <= 1'b0;
         ferr <= 1'b0;
      end else begin
         push <= 1'b0;
         if (tick) begin
            tcnt <= tcnt + 1'b1;
            unique case (st)
               RX_IDLE: begin
                  tcnt <= '0;
                  if (!rx_s) st <= RX_START;
               end
               RX_START: if (tcnt == OVS_W'(OVS/2-1)) begin
                  tcnt <= '0;
                  bitn <= '0;
                  st   <= rx_s ? RX_IDLE : RX_DATA;
               end
               RX_DATA: if (tcnt == OVS_W'(OVS-1)) begin
                  data <= {rx_s, data[7:1]};
                  bitn <= bitn + 1'b1;
                  if (bitn == 3'd7) st <= RX_STOP;
               end
               RX_STOP: if (tcnt == OVS_W'(OVS-1)) begin
                  push <= 1'b1;
                  ferr <= !rx_s;
                  st   <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/fcuart_top.sv
module fcuart_top
   import fcuart_pkg::*;
#(
   parameter int            TX_DEPTH = 4,
   parameter int            RX_DEPTH = 4,
   parameter int            SYNC     = 2,
   parameter logic [11:0]   DIV_RST  = 12'd16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       txd_o,
   input  logic       rxd_i,
   input  logic       cts_i,
   output logic       rts_o
);
   logic [DIV_W-1:0] div;
   logic             hs_en, ovr, tick;
   logic             tx_full, tx_empty, tx_pop, tx_busy, start_ok;
   logic [7:0]       tx_head;
   logic             rx_full, rx_empty, rx_push, rx_ferr, rx_pop;
   logic [7:0]       rx_byte;
   logic [8:0]       rx_head;
   logic             tx_wr;

   assign tx_wr    = wr_en && (addr == REG_DATA);
   assign rx_pop   = rd_en && (addr == REG_DATA);
   assign start_ok = !tx_empty && (!hs_en || cts_i);
   assign rts_o    = !(hs_en && rx_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div   <= DIV_RST;
         hs_en <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         if (wr_en && addr == REG_DIVL) div[7:0] <= wdata;
         if (wr_en && addr == REG_CTRL) begin
            div[11:8] <= wdata[3:0];
            hs_en     <= wdata[7];
         end
         if (rx_push && rx_full)                      ovr <= 1'b1;
         else if (wr_en && addr == REG_STAT && wdata[4]) ovr <= 1'b0;
      end
   end

   always_comb begin
      unique case (addr)
         REG_DATA: rdata = rx_head[7:0];
         REG_STAT: rdata = {1'b0, tx_busy, rx_head[8] && !rx_empty, ovr,
                            rx_full, rx_empty, tx_empty, tx_full};
         REG_DIVL: rdata = div[7:0];
         default:  rdata = {hs_en, 3'b000, div[11:8]};
      endcase
   end

   fcuart_baud u_baud (.clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

   fcuart_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(wdata), .pop(tx_pop),
      .dout(tx_head), .full(tx_full), .empty(tx_empty), .count());

   fcuart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_ok(start_ok), .data(tx_head),
      .pop(tx_pop), .busy(tx_busy), .txd(txd_o));

   fcuart_rx #(.SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_i),
      .push(rx_push), .data(rx_byte), .ferr(rx_ferr));

   fcuart_fifo #(.W(9), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din({rx_ferr, rx_byte}), .pop(rx_pop),
      .dout(rx_head), .full(rx_full), .empty(rx_empty), .count());

   // R5
   cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en && !cts_i && !tx_busy |=> !tx_busy);
   // R8
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rx_full) && $past(rx_push));
   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd_o);
endmodule

// File: tb/fcuart_top_tb_top.sv
`timescale 1ns/1ps
module fcuart_top_tb_top;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       txd_o, rts_o;
   logic       rxd_i = 1'b1, cts_i = 1'b1;
   int checks = 0, errors = 0;
   int bitc = 32;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   fcuart_top dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .txd_o(txd_o), .rxd_i(rxd_i), .cts_i(cts_i), .rts_o(rts_o));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic pop, output logic [7:0] d);
      @(negedge clk); addr = a; #0.5; d = rdata; rd_en = pop;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic cap(input logic drop_cts, output logic [7:0] b, output logic stop);
      @(negedge clk);
      while (txd_o) @(negedge clk);
      if (drop_cts) cts_i = 1'b0;
      repeat (bitc/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (bitc) @(negedge clk);
         b[i] = txd_o;
      end
      repeat (bitc) @(negedge clk);
      stop = txd_o;
   endtask

   task automatic send(input logic [7:0] b, input logic stopv);
      @(negedge clk); rxd_i = 1'b0;
      repeat (bitc) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd_i = b[i];
         repeat (bitc) @(negedge clk);
      end
      rxd_i = stopv;
      repeat (bitc) @(negedge clk);
      rxd_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic quiet(input int n, input string tag);
      int lows = 0;
      repeat (n) begin @(negedge clk); if (!txd_o) lows++; end
      chk(lows == 0, tag, lows, 0);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk(txd_o && rts_o, "R1 lines", {txd_o, rts_o}, 3);
      rd(2'd1, 1'b0, d); chk(d == 8'h06, "R1 status", d, 8'h06);
      rd(2'd2, 1'b0, d); chk(d == 8'd16, "R1 divisor", d, 16);
   endtask

   task automatic t_tx_basic;
      logic [7:0] b; logic s;
      wr(2'd2, 8'd2); wr(2'd3, 8'h00); bitc = 32;
      wr(2'd0, 8'hA5);
      cap(1'b0, b, s);
      chk(b == 8'hA5 && s, "R2 tx frame", {s, b}, 9'h1A5);
   endtask

   task automatic t_tx_fifo_cts;
      logic [7:0] b, d; logic s;
      wr(2'd3, 8'h80); cts_i = 1'b0;
      for (int i = 0; i < 5; i++) wr(2'd0, 8'h11 + 8'(i));
      rd(2'd1, 1'b0, d); chk(d[0] == 1'b1, "R4 tx full flag", d[0], 1);
      quiet(12*bitc, "R5 held by cts");
      cts_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         cap(1'b0, b, s);
         chk(b == 8'h11 + 8'(i), "R4 tx order", b, 8'h11 + i);
      end
      quiet(24*bitc, "R4 fifth write discarded");
   endtask

   task automatic t_cts_mid;
      logic [7:0] b; logic s;
      wr(2'd0, 8'h5A);
      cap(1'b1, b, s);
      chk(b == 8'h5A && s, "R5 char completes", {s, b}, 9'h15A);
      wr(2'd0, 8'h77);
      quiet(24*bitc, "R5 next held");
      cts_i = 1'b1;
      cap(1'b0, b, s);
      chk(b == 8'h77, "R5 resumes", b, 8'h77);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_rx_basic;
      logic [7:0] d;
      send(8'h3C, 1'b1);
      rd(2'd1, 1'b0, d); chk(d[2] == 1'b0 && d[5] == 1'b0, "R6 rx status", d, 0);
      rd(2'd0, 1'b1, d); chk(d == 8'h3C, "R6 rx data", d, 8'h3C);
      rd(2'd1, 1'b0, d); chk(d[2] == 1'b1, "R6 rx emptied", d[2], 1);
   endtask

   task automatic t_frame;
      logic [7:0] d;
      send(8'h96, 1'b0);
      repeat (2*bitc) @(negedge clk);
      rd(2'd1, 1'b0, d); chk(d[5] == 1'b1, "R9 frame flag", d[5], 1);
      rd(2'd0, 1'b1, d); chk(d == 8'h96, "R9 frame data", d, 8'h96);
      rd(2'd1, 1'b0, d); chk(d[2] == 1'b1 && d[5] == 1'b0, "R9 one byte only", d, 8'h04);
   endtask

   task automatic t_glitch;
      logic [7:0] d;
      @(negedge clk); rxd_i = 1'b0;
      repeat (bitc/4) @(negedge clk);
      rxd_i = 1'b1;
      repeat (12*bitc) @(negedge clk);
      rd(2'd1, 1'b0, d); chk(d[2] == 1'b1, "R10 glitch rejected", d[2], 1);
   endtask

   task automatic t_overrun;
      logic [7:0] d;
      wr(2'd3, 8'h80);
      for (int i = 0; i < 4; i++) send(8'hC0 + 8'(i), 1'b1);
      chk(rts_o == 1'b0, "R7 rts low when full", rts_o, 0);
      rd(2'd1, 1'b0, d); chk(d[3] && !d[4], "R7 full no overrun", d, 8'h08);
      send(8'hEE, 1'b1);
      rd(2'd1, 1'b0, d); chk(d[4] == 1'b1, "R8 overrun set", d[4], 1);
      rd(2'd0, 1'b1, d); chk(d == 8'hC0, "R8 first kept", d, 8'hC0);
      @(negedge clk); chk(rts_o == 1'b1, "R7 rts back", rts_o, 1);
      for (int i = 1; i < 4; i++) begin
         rd(2'd0, 1'b1, d); chk(d == 8'hC0 + 8'(i), "R8 order, drop", d, 8'hC0 + i);
      end
      rd(2'd1, 1'b0, d); chk(d[2] && d[4], "R8 empty, sticky", d, 8'h14);
      wr(2'd1, 8'h10);
      rd(2'd1, 1'b0, d); chk(d[4] == 1'b0, "R8 cleared", d[4], 0);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_divisor;
      logic [7:0] b, d; logic s; int n;
      wr(2'd2, 8'd5); wr(2'd3, 8'h00); bitc = 80;
      rd(2'd2, 1'b0, d); chk(d == 8'd5, "R3 divisor read", d, 5);
      wr(2'd0, 8'hC3);
      @(negedge clk);
      while (txd_o) @(negedge clk);
      n = 0;
      while (!txd_o) begin n++; @(negedge clk); end
      chk(n == 80, "R2 R3 bit length", n, 80);
      repeat (20*bitc) @(negedge clk);
      wr(2'd0, 8'h3A);
      cap(1'b0, b, s);
      chk(b == 8'h3A && s, "R3 frame at new rate", {s, b}, 9'h13A);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_tx_basic;
      t_tx_fifo_cts;
      t_cts_mid;
      bitc = 32;
      t_rx_basic;
      t_frame;
      t_glitch;
      t_overrun;
      t_divisor;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule